// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block produces memory addresses for a signal-processing datapath. It keeps a pointer, a lower bound, an upper bound, a step and a bit count. For each accepted request it emits one effective address and then moves the pointer on. Three addressing modes are available. The linear mode adds the step after each use. The circular mode keeps the pointer inside a buffer bounded by the lower and upper bounds. The bit-reversed mode reorders data for FFT passes over a programmable number of low address bits.

Configuration uses a plain write port. Requests come in on a valid/ready handshake and addresses go out on a second one. A request is accepted only when the output slot is empty or is being drained in the same cycle. While `addr_valid` is high and `addr_ready` is low, the address on `addr_out` is held unchanged and no new request is taken. A configuration write holds `req_ready` low for that cycle, so the write always wins over a request.

Top module: `circ_bitrev_agu`

## Requirements
- R1: After reset `addr_valid` is 0, `req_ready` is 1, and the pointer, bounds and step are all 0 in linear mode, so the first request emits address 0.
- R2: With `cfg_we` high, `cfg_wdata` is written to the register chosen by `cfg_sel` (0 pointer, 1 lower bound, 2 upper bound, 3 step, 4 mode, 5 bit count). Codes 6 and 7 change nothing. The new value is used from the next accepted request on.
- R3: While `cfg_we` is high, `req_ready` is 0 and no request is accepted in that cycle.
- R4: A request accepted at a clock edge sets `addr_valid` after that edge, with its address on `addr_out`. While `addr_ready` is low the address stays stable and `req_ready` is 0. Otherwise `req_ready` equals `!addr_valid || addr_ready` when no write is pending.
- R5: Linear mode (code 0) emits the pointer, then adds the step to it modulo 2^AW.
- R6: Circular mode (code 1) emits the pointer, then forms pointer+step. If that sum is above the upper bound, the pointer becomes sum-(upper-lower+1), which is the lower bound plus the overshoot. A sum equal to the upper bound is kept as it is.
- R7: Bit-reversed mode (code 2) emits lower bound + R(pointer). R reverses the low N bits of the pointer and passes the upper bits through unchanged. For example, 12 over 4 bits gives 3, and 6 over 3 bits gives 3. The pointer then advances by exactly 1, whatever the step is.
- R8: The bit count N is taken from the low bits of its register. A value of 0 acts as 1, and a value above AW acts as AW.
- R9: Mode code 3 behaves as linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | AW | Write data |
| req_valid | input | 1 | Address request valid |
| req_ready | output | 1 | Request can be accepted |
| addr_valid | output | 1 | Emitted address valid |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | AW | Effective address |

## Verification
`req_ready` is combinational, so it is checked in the same cycle as the stimulus. That covers both the write-priority case and the back-pressure case. An accepted request shows up on `addr_out` one clock after the edge that accepted it. The bench drives inputs on the falling edge and samples at the following falling edge, half a cycle after the accepting edge. A configuration write is done in its own cycle before the request that observes it. Each mode's pointer update is therefore checked through the address emitted by the next request.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_CIRC = 2'd1,
    MODE_REV  = 2'd2,
    MODE_RSV  = 2'd3
  } agu_mode_e;

  localparam logic [2:0] SEL_PTR  = 3'd0;
  localparam logic [2:0] SEL_LO   = 3'd1;
  localparam logic [2:0] SEL_HI   = 3'd2;
  localparam logic [2:0] SEL_STEP = 3'd3;
  localparam logic [2:0] SEL_MODE = 3'd4;
  localparam logic [2:0] SEL_NB   = 3'd5;
endpackage

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW = 16,
  parameter int NW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] val,
  input  logic [NW-1:0] nbits,
  output logic [AW-1:0] result
);
  logic [AW-1:0] full_rev;
  logic [AW-1:0] low_rev;
  logic [AW-1:0] mask;
  int unsigned   n_eff;

  // Reverse all AW bits; shifting down then leaves the low n reversed.
  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign full_rev[i] = val[AW-1-i];
  end

  always_comb begin
    if (nbits == '0)          n_eff = 1;
    else if (int'(nbits) > AW) n_eff = AW;
    else                      n_eff = int'(nbits);
    low_rev = full_rev >> (AW - n_eff);
    mask    = {AW{1'b1}} >> (AW - n_eff);
    result  = (val & ~mask) | (low_rev & mask);
  end
endmodule

// File: rtl/agu_step.sv
module agu_step
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int NW = $clog2(AW + 1)
) (
  input  agu_mode_e     mode,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] step,
  input  logic [NW-1:0] nbits,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] ptr_next
);
  logic [AW-1:0] rev_ptr;
  logic [AW:0]   sum;
  logic [AW:0]   span;

  agu_bitrev #(.AW(AW), .NW(NW)) u_rev (
    .val    (ptr),
    .nbits  (nbits),
    .result (rev_ptr)
  );

  always_comb begin
    sum  = {1'b0, ptr} + {1'b0, step};
    span = {1'b0, hi} - {1'b0, lo} + 1'b1;
    case (mode)
      MODE_CIRC: begin
        eff_addr = ptr;
        if (sum > {1'b0, hi}) ptr_next = AW'(sum - span);
        else                  ptr_next = sum[AW-1:0];
      end
      MODE_REV: begin
        eff_addr = lo + rev_ptr;
        ptr_next = ptr + 1'b1;
      end
      default: begin
        eff_addr = ptr;
        ptr_next = sum[AW-1:0];
      end
    endcase
  end
endmodule

// File: rtl/circ_bitrev_agu.sv
module circ_bitrev_agu
  import agu_pkg::*;
#(
  parameter int AW = 16,
  localparam int NW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out
);
  logic [AW-1:0] cur_q, lo_q, hi_q, step_q;
  logic [NW-1:0] nb_q;
  agu_mode_e     mode_q;
  logic [AW-1:0] eff_addr, ptr_next;
  logic          take;

  assign req_ready = !cfg_we && (!addr_valid || addr_ready);
  assign take      = req_valid && req_ready;

  agu_step #(.AW(AW), .NW(NW)) u_step (
    .mode     (mode_q),
    .ptr      (cur_q),
    .lo       (lo_q),
    .hi       (hi_q),
    .step     (step_q),
    .nbits    (nb_q),
    .eff_addr (eff_addr),
    .ptr_next (ptr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      step_q <= '0;
      nb_q   <= NW'(1);
      mode_q <= MODE_LIN;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_PTR:  cur_q  <= cfg_wdata;
        SEL_LO:   lo_q   <= cfg_wdata;
        SEL_HI:   hi_q   <= cfg_wdata;
        SEL_STEP: step_q <= cfg_wdata;
        SEL_MODE: mode_q <= agu_mode_e'(cfg_wdata[1:0]);
        SEL_NB:   nb_q   <= cfg_wdata[NW-1:0];
        default: ;
      endcase
    end else if (take) begin
      cur_q <= ptr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else if (take) begin
      addr_valid <= 1'b1;
      addr_out   <= eff_addr;
    end else if (addr_ready) begin
      addr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          req_valid,
  input logic          req_ready,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] cur_q,
  input agu_mode_e     mode_q
);
  a_r3_write_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !req_ready);

  a_r4_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  a_r4_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |-> !req_ready);

  a_r4_valid_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> $past(req_valid && req_ready));

  a_r7_rev_ptr_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode_q == MODE_REV) |=> (cur_q == AW'($past(cur_q) + 1'b1)));
endmodule

bind circ_bitrev_agu agu_checker #(.AW(AW)) u_agu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr_out   (addr_out),
  .cur_q      (cur_q),
  .mode_q     (mode_q)
);

// File: tb/circ_bitrev_agu_test.sv
`timescale 1ns/1ps
module circ_bitrev_agu_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          addr_valid;
  logic          addr_ready = 1'b1;
  logic [AW-1:0] addr_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  circ_bitrev_agu #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic req(input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; addr_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(addr_valid == 1'b1, {tag, " valid"}, addr_valid, 1);
    check(addr_out == exp, tag, addr_out, exp);
  endtask

  task automatic t_reset;
    check(addr_valid == 1'b0, "R1 addr_valid after reset", addr_valid, 0);
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    req(16'h0000, "R1 first address");
    req(16'h0000, "R1 zero step");
  endtask

  task automatic t_linear;
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd100);
    wr(3'd3, 16'd3);
    req(16'd100, "R5 lin a");
    req(16'd103, "R5 lin b");
    req(16'd106, "R5 lin c");
    wr(3'd0, 16'hFFFE);
    req(16'hFFFE, "R5 lin top");
    req(16'h0001, "R5 lin modulo");
  endtask

  task automatic t_circular;
    wr(3'd4, 16'd1);
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd15);
    wr(3'd3, 16'd4);
    wr(3'd0, 16'd10);
    req(16'd10, "R6 circ a");
    req(16'd14, "R6 circ b");
    req(16'd12, "R6 circ wrap overshoot");
    req(16'd10, "R6 circ wrap to lower");
    wr(3'd3, 16'd5);
    wr(3'd0, 16'd10);
    req(16'd10, "R6 circ c");
    req(16'd15, "R6 circ equal upper kept");
    req(16'd14, "R6 circ after upper");
  endtask

  task automatic t_bitrev;
    wr(3'd4, 16'd2);
    wr(3'd1, 16'h0100);
    wr(3'd5, 16'd4);
    wr(3'd3, 16'd7);
    wr(3'd0, 16'd12);
    req(16'h0103, "R7 rev 12 over 4");
    req(16'h010B, "R7 rev next is ptr+1");
    wr(3'd1, 16'h0000);
    wr(3'd5, 16'd3);
    wr(3'd0, 16'h0026);
    req(16'h0023, "R7 rev 6 over 3 upper pass");
    req(16'h0027, "R7 rev 7 over 3");
  endtask

  task automatic t_nbits_clamp;
    wr(3'd5, 16'd0);
    wr(3'd0, 16'h0006);
    req(16'h0006, "R8 nbits zero as one");
    wr(3'd5, 16'd20);
    wr(3'd0, 16'h0001);
    req(16'h8000, "R8 nbits above width");
  endtask

  task automatic t_mode3;
    wr(3'd4, 16'd3);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'd1);
    req(16'd1, "R9 mode3 a");
    req(16'd6, "R9 mode3 linear step");
  endtask

  task automatic t_priority;
    wr(3'd4, 16'd0);
    wr(3'd3, 16'd1);
    wr(3'd0, 16'd40);
    @(negedge clk);
    req_valid = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'd200;
    #1;
    check(req_ready == 1'b0, "R3 ready low during write", req_ready, 0);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check(addr_valid == 1'b0, "R3 no accept on write", addr_valid, 0);
    req(16'd200, "R2 written pointer used");
    wr(3'd6, 16'd999);
    req(16'd201, "R2 unused select ignored");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    req_valid = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    check(addr_valid == 1'b1, "R4 valid under stall", addr_valid, 1);
    check(addr_out == 16'd202, "R4 stalled addr", addr_out, 202);
    for (int i = 0; i < 3; i++) begin
      check(req_ready == 1'b0, "R4 ready low while full", req_ready, 0);
      @(negedge clk);
      check(addr_out == 16'd202, "R4 addr held", addr_out, 202);
    end
    addr_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R4 ready with drain", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(addr_out == 16'd203, "R4 next after drain", addr_out, 203);
    @(negedge clk);
    check(addr_valid == 1'b0, "R4 empties", addr_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_linear();
    t_circular();
    t_bitrev();
    t_nbits_clamp();
    t_mode3();
    t_priority();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule